// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the raw A, B and Z lines of an incremental rotary or linear encoder into a signed position value. The lines arrive already digital but unrelated to the system clock. Each line is first brought into the clock domain and then deglitched. Every rising and falling edge of A and B then becomes one count step with a direction. The steps are summed into a wrapping two's-complement position, so one full electrical period of the encoder moves the position by four.

A rising edge on the filtered Z line raises a one-cycle index strobe. When the index-clear enable is set, the same event returns the position to zero. A synchronous clear input zeroes the position at any time. The current direction is also available as an output. If A and B both change in the same cycle, the block flags it as an illegal transition on a one-cycle error output, and only the A edge is counted.

The accumulator acts on the trailing edge of each one-cycle count pulse. As a result, the direction flag is always one full clock older than the update that uses it. Inputs are expected to change no more often than once every six system clocks.

Top module: `qdec_position_counter`

## Requirements
- R1: Each of A, B and Z passes through a two-flop synchronizer and then a four-stage agreement filter. The filtered level changes only after four consecutive synchronized samples agree. A pulse on any raw line that lasts fewer than four clocks changes neither `position`, `dir_up`, `index_pulse` nor `edge_err`.
- R2: Every rising and every falling edge of filtered A and filtered B is one count, so a full quadrature period moves `position` by exactly four.
- R3: Direction is up (`dir_up`=1, position +1) in four cases: A rises while B is low, A falls while B is high, B rises while A is high, or B falls while A is low. Every other edge counts down. Each step of the cycle AB = 00→10→11→01→00 (A leading B, clockwise) counts up, and the reverse order counts down.
- R4: If edges of both A and B fall in the same clock, only the A edge is counted, using the new level of B. `edge_err` is then high for exactly one clock.
- R5: The position update happens on the trailing edge of the internal count pulse. After a single valid input change, `position` holds its old value for at least 6 clocks and shows the new value within 12 clocks.
- R6: `position` is a 32-bit two's-complement value that wraps. One down count from 0 gives 32'hFFFF_FFFF.
- R7: `clr` high at a clock edge sets `position` to zero at that edge. It has priority over counting and over the index event.
- R8: A rising edge of filtered Z produces `index_pulse` high for exactly one clock. A falling edge of Z produces no strobe.
- R9: When `idx_clr_en` is high during `index_pulse`, `position` becomes zero at the next clock edge. When it is low, the index event leaves `position` unchanged.
- R10: While `rst_n` is low, and right after it is released, `position` is 0 and `dir_up`, `index_pulse` and `edge_err` are 0. The reset is applied asynchronously and released synchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder channel A, asynchronous |
| enc_b | input | 1 | Raw encoder channel B, asynchronous |
| enc_z | input | 1 | Raw encoder index channel, asynchronous |
| clr | input | 1 | Synchronous position clear |
| idx_clr_en | input | 1 | Zero the position on each index event |
| position | output | 32 | Signed accumulated position |
| dir_up | output | 1 | Direction of the most recent count (1 = up) |
| index_pulse | output | 1 | One-cycle strobe on a rising edge of filtered Z |
| edge_err | output | 1 | One-cycle flag for simultaneous A and B edges |

## Verification
Directed clockwise and counter-clockwise cycles show whether each of the four edge kinds picks the right direction and whether a full period adds four. A random walk mixes forward, reverse and pause steps, so it exposes errors that appear only when the direction reverses in mid-cycle. Spikes of three clocks on each line show whether the filter depth is correct. A simultaneous change of A and B shows the priority rule, separately from normal counting. A step down from zero, Z pulses with the enable low and then high, and a clear tell apart the wrap, the index-zero and the clear paths.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_RISE = 2'd1,
    EV_FALL = 2'd2
  } edge_kind_t;

  // Classify one filtered line from its previous and present samples.
  function automatic edge_kind_t edge_of(input logic prev_lvl, input logic cur_lvl);
    edge_kind_t k;
    case ({prev_lvl, cur_lvl})
      2'b01:   k = EV_RISE;
      2'b10:   k = EV_FALL;
      default: k = EV_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/qdec_rst_sync.sv
module qdec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_n;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_line_filter.sv
module qdec_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_STAGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  logic [SYNC_STAGES-1:0] sync_q, sync_n;
  logic [FILT_STAGES-1:0] win_q,  win_n;
  logic                   lvl_q,  lvl_n;

  always_comb begin
    sync_n = {sync_q[SYNC_STAGES-2:0], raw};
    win_n  = {win_q[FILT_STAGES-2:0], sync_q[SYNC_STAGES-1]};
    if (&win_q)       lvl_n = 1'b1;
    else if (~|win_q) lvl_n = 1'b0;
    else              lvl_n = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      win_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= sync_n;
      win_q  <= win_n;
      lvl_q  <= lvl_n;
    end
  end

  assign level = lvl_q;

  // R1: a level change is only allowed after the whole window agreed on it
  a_r1_filter_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(win_q) == {FILT_STAGES{lvl_q}}));
endmodule

// File: rtl/qdec_edge_decode.sv
module qdec_edge_decode
  import qdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic cnt_pulse,
  output logic dir_up,
  output logic edge_err
);
  logic a_prev_q, b_prev_q;
  logic cnt_q, cnt_n;
  logic up_q,  up_n;
  logic err_q, err_n;
  edge_kind_t ev_a, ev_b;

  always_comb begin
    ev_a  = edge_of(a_prev_q, a_lvl);
    ev_b  = edge_of(b_prev_q, b_lvl);
    cnt_n = (ev_a != EV_NONE) || (ev_b != EV_NONE);
    err_n = (ev_a != EV_NONE) && (ev_b != EV_NONE);
    up_n  = up_q;
    // A has priority; the other line's present filtered level decides
    if (ev_a == EV_RISE)      up_n = ~b_lvl;
    else if (ev_a == EV_FALL) up_n = b_lvl;
    else if (ev_b == EV_RISE) up_n = a_lvl;
    else if (ev_b == EV_FALL) up_n = ~a_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
      cnt_q    <= 1'b0;
      up_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      a_prev_q <= a_lvl;
      b_prev_q <= b_lvl;
      cnt_q    <= cnt_n;
      up_q     <= up_n;
      err_q    <= err_n;
    end
  end

  assign cnt_pulse = cnt_q;
  assign dir_up    = up_q;
  assign edge_err  = err_q;

  // R4: an illegal double edge is still counted once
  a_r4_err_with_count: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> cnt_q);
  // R3: direction only moves together with a count
  a_r3_dir_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q != $past(up_q)) |-> cnt_q);
endmodule

// File: rtl/qdec_accum.sv
module qdec_accum #(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             zero_evt,
  input  logic             cnt_pulse,
  input  logic             dir_up,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  logic             cnt_d_q;
  logic             step;
  logic [POS_W-1:0] pos_q, pos_n;

  always_comb begin
    step = cnt_d_q & ~cnt_pulse;   // trailing edge of the count pulse
    if (clr)           pos_n = '0;
    else if (zero_evt) pos_n = '0;
    else if (step)     pos_n = dir_up ? (pos_q + ONE) : (pos_q - ONE);
    else               pos_n = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_d_q <= 1'b0;
      pos_q   <= '0;
    end else begin
      cnt_d_q <= cnt_pulse;
      pos_q   <= pos_n;
    end
  end

  assign pos = pos_q;

  // R7: clear wins over everything
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pos_q == '0));
  // R6: position only moves by one step (with wrap) or to zero
  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != $past(pos_q)) |->
      ((pos_q == $past(pos_q) + ONE) || (pos_q == $past(pos_q) - ONE) || (pos_q == '0)));
  // R5: no update while the count pulse is still high
  a_r5_trailing_update: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && !clr && !zero_evt) |=> $stable(pos_q));
endmodule

// File: rtl/qdec_position_counter.sv
module qdec_position_counter
  import qdec_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_STAGES = 4,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_z,
  input  logic             clr,
  input  logic             idx_clr_en,
  output logic [POS_W-1:0] position,
  output logic             dir_up,
  output logic             index_pulse,
  output logic             edge_err
);
  localparam int N_LINES = 3;
  localparam int LN_A    = 0;
  localparam int LN_B    = 1;
  localparam int LN_Z    = 2;

  logic               rst_sn;
  logic [N_LINES-1:0] raw_vec;
  logic [N_LINES-1:0] lvl_vec;
  logic               cnt_pulse;
  logic               z_prev_q, idx_q, idx_n;
  logic               zero_evt;

  qdec_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  assign raw_vec = {enc_z, enc_b, enc_a};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    qdec_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_STAGES (FILT_STAGES)
    ) u_flt (
      .clk   (clk),
      .rst_n (rst_sn),
      .raw   (raw_vec[g]),
      .level (lvl_vec[g])
    );
  end

  qdec_edge_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_sn),
    .a_lvl     (lvl_vec[LN_A]),
    .b_lvl     (lvl_vec[LN_B]),
    .cnt_pulse (cnt_pulse),
    .dir_up    (dir_up),
    .edge_err  (edge_err)
  );

  always_comb begin
    idx_n = (edge_of(z_prev_q, lvl_vec[LN_Z]) == EV_RISE);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      z_prev_q <= 1'b0;
      idx_q    <= 1'b0;
    end else begin
      z_prev_q <= lvl_vec[LN_Z];
      idx_q    <= idx_n;
    end
  end

  assign index_pulse = idx_q;
  assign zero_evt    = idx_q & idx_clr_en;

  qdec_accum #(.POS_W(POS_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_sn),
    .clr       (clr),
    .zero_evt  (zero_evt),
    .cnt_pulse (cnt_pulse),
    .dir_up    (dir_up),
    .pos       (position)
  );

  // R8: the index strobe never lasts more than one clock
  a_r8_index_single: assert property (@(posedge clk) disable iff (!rst_sn)
    index_pulse |=> !index_pulse);
  // R9: index with enable zeroes the position
  a_r9_index_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (index_pulse && idx_clr_en) |=> (position == '0));
  // R4: the error flag is a single-cycle pulse under legal input spacing
  a_r4_err_single: assert property (@(posedge clk) disable iff (!rst_sn)
    edge_err |=> !edge_err);
  // R10: outputs are quiet while held in reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_sn |-> (position == '0 && !dir_up && !index_pulse && !edge_err));
endmodule

// File: tb/sim_qdec_position_counter.sv
module sim_qdec_position_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_a, enc_b, enc_z, clr, idx_clr_en;
  logic [31:0] position;
  logic        dir_up, index_pulse, edge_err;

  int n_checks = 0;
  int n_errors = 0;
  int err_seen = 0;
  int idx_seen = 0;
  bit done     = 0;

  logic [31:0] pos_m;
  logic        a_m, b_m, dir_m;
  int          err_m, idx_m;

  always #4 clk = ~clk;   // 125 MHz

  qdec_position_counter u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .clr(clr), .idx_clr_en(idx_clr_en), .position(position), .dir_up(dir_up),
    .index_pulse(index_pulse), .edge_err(edge_err)
  );

  always @(negedge clk) begin
    if (rst_n && edge_err)    err_seen++;
    if (rst_n && index_pulse) idx_seen++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Direction rule from R3/R4: +1, -1 or 0 for a change of (a,b)
  function automatic int step_delta(logic oa, logic ob, logic na, logic nb);
    bit up;
    if (na != oa) begin
      up = na ? !nb : nb;
      return up ? 1 : -1;
    end
    if (nb != ob) begin
      up = nb ? na : !na;
      return up ? 1 : -1;
    end
    return 0;
  endfunction

  // Quadrature phase order for A leading B: 00,10,11,01
  function automatic logic [1:0] phase_ab(int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int ab_phase(logic a, logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic drive_ab(input logic na, input logic nb);
    int d;
    d = step_delta(a_m, b_m, na, nb);
    if (d != 0) begin
      pos_m = pos_m + 32'(d);
      dir_m = (d > 0);
    end
    if ((na != a_m) && (nb != b_m)) err_m++;
    a_m = na; b_m = nb;
    @(negedge clk);
    enc_a = na; enc_b = nb;
    repeat (8) @(negedge clk);
  endtask

  task automatic move(input bit cw);
    int p;
    logic [1:0] ab;
    p  = ab_phase(a_m, b_m) + (cw ? 1 : 3);
    ab = phase_ab(p);
    drive_ab(ab[1], ab[0]);
  endtask

  task automatic spike(input int line);
    @(negedge clk);
    case (line)
      0: enc_a = ~enc_a;
      1: enc_b = ~enc_b;
      default: enc_z = ~enc_z;
    endcase
    repeat (3) @(negedge clk);
    case (line)
      0: enc_a = ~enc_a;
      1: enc_b = ~enc_b;
      default: enc_z = ~enc_z;
    endcase
    settle();
  endtask

  task automatic z_pulse();
    @(negedge clk); enc_z = 1'b1;
    repeat (8) @(negedge clk); enc_z = 1'b0;
    idx_m++;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; enc_a = 0; enc_b = 0; enc_z = 0; clr = 0; idx_clr_en = 0;
    pos_m = '0; a_m = 0; b_m = 0; dir_m = 0; err_m = 0; idx_m = 0;
    repeat (5) @(negedge clk);
    chk("R10 position in reset", position, 32'h0);
    chk("R10 flags in reset", {29'h0, dir_up, index_pulse, edge_err}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 position after reset", position, 32'h0);

    // R5: latency window of a single up step
    @(negedge clk); enc_a = 1'b1; a_m = 1'b1; pos_m = 32'd1; dir_m = 1;
    repeat (6) @(negedge clk);
    chk("R5 no early update", position, 32'h0);
    repeat (6) @(negedge clk);
    chk("R5 update within 12 clocks", position, 32'd1);
    chk("R3 A rise with B low is up", {31'h0, dir_up}, 32'd1);

    // R2/R3: rest of the clockwise period, then a counter-clockwise period
    for (int i = 0; i < 3; i++) move(1'b1);
    settle();
    chk("R2 one clockwise period adds four", position, 32'd4);
    chk("R3 clockwise direction", {31'h0, dir_up}, 32'd1);
    for (int i = 0; i < 4; i++) move(1'b0);
    settle();
    chk("R2 one counter-clockwise period subtracts four", position, 32'd0);
    chk("R3 counter-clockwise direction", {31'h0, dir_up}, 32'd0);

    // R6: wrap below zero
    move(1'b0);
    settle();
    chk("R6 wrap from 0 to all ones", position, 32'hFFFF_FFFF);
    move(1'b1);
    settle();
    chk("R6 wrap back to zero", position, pos_m);

    // R1: short spikes on every line
    for (int l = 0; l < 3; l++) spike(l);
    chk("R1 spikes leave position", position, pos_m);
    chk("R1 spikes leave direction", {31'h0, dir_up}, {31'h0, dir_m});
    chk("R1 spikes raise no index or error", 32'(idx_seen + err_seen), 32'd0);

    // R4: simultaneous A and B change from 00 to 11
    drive_ab(1'b1, 1'b1);
    settle();
    chk("R4 simultaneous edges count A only", position, pos_m);
    chk("R4 error pulse count", 32'(err_seen), 32'(err_m));
    chk("R4 direction follows A rule", {31'h0, dir_up}, {31'h0, dir_m});

    // Random walk
    for (int i = 0; i < 80; i++) begin
      int r;
      r = $urandom_range(2, 0);
      if (r == 0)      move(1'b1);
      else if (r == 1) move(1'b0);
      else             repeat (6) @(negedge clk);
      if ((i % 20) == 19) begin
        settle();
        chk("R2 random walk position", position, pos_m);
        chk("R3 random walk direction", {31'h0, dir_up}, {31'h0, dir_m});
      end
    end

    // R8/R9: index events
    idx_clr_en = 1'b0;
    z_pulse();
    chk("R8 index strobe counted once", 32'(idx_seen), 32'(idx_m));
    chk("R9 index without enable keeps position", position, pos_m);
    for (int i = 0; i < 3; i++) move(1'b1);
    settle();
    idx_clr_en = 1'b1;
    z_pulse();
    pos_m = '0;
    chk("R9 index with enable zeroes position", position, 32'h0);
    chk("R8 strobe count after second index", 32'(idx_seen), 32'(idx_m));
    idx_clr_en = 1'b0;

    // R7: synchronous clear
    for (int i = 0; i < 5; i++) move(1'b0);
    settle();
    chk("R7 position before clear", position, pos_m);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    pos_m = '0;
    chk("R7 clear zeroes position", position, 32'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule